// File: doc/BRIEF.md
# Segment Blink and Display-Memory Controller

This block decides, frame by frame, whether each segment of a multiplexed segment display is lit. It holds two bit arrays with the same layout: a main display memory and a secondary memory. The secondary memory either flags individual segments for blinking or serves as a second picture. A global display-on input gates every segment. A two-bit mode input selects one of four behaviours: no blinking, blinking of the flagged segments only, blinking of every segment, or automatic alternation between the two pictures. A blink divider counts pulses of the display source clock and sets the length of each blink half-period.

Every visible change waits for the frame-boundary strobe. This covers memory writes, blanking, blink phases, picture swaps and clearing of the secondary memory. The segment outputs are a register that loads only in the cycle a strobe is present. When a high multiplex ratio is in use, the secondary memory is not used. Only whole-display blinking remains available in that case.

Top module: `segBlinkCtl`

## Requirements
- R1: `segOut` loads only on a clock edge at which `frameStb` is 1, so it changes only in the cycle after a strobe and holds its value at every other edge. After reset it is all zeros.
- R2: At a strobe with `dispOn` = 0, `segOut` becomes all zeros. With `dispOn` = 1 and no blanking active, each bit equals the selected memory's bit for that segment.
- R3: In mode 00 with `highMux` = 0, `dispSel` = 0 shows the main memory and `dispSel` = 1 shows the secondary memory, from the next strobe onward.
- R4: In mode 01, the main memory is shown. During the off half-period, every segment whose secondary-memory bit is 1 is forced off.
- R5: In mode 10, every segment is forced off during the off half-period. During the on half-period, the main memory is shown.
- R6: In mode 11 with `highMux` = 0, the display alternates between the two memories once per half-period. The secondary memory is shown first.
- R7: With `highMux` = 1, modes 01 and 11 act like mode 00, and only the main memory is shown whatever `dispSel` is. Mode 10 still blanks every segment during its off half-period.
- R8: The divider is held at zero, in the off phase, while the effective mode is 00. Once a mode is entered, the first strobe blanks. The phase flips after (`blkDiv`+1)·2^(8+`blkPre`) `srcTick` pulses, and the first strobe after that flip restores the segments.
- R9: A `clrReq` pulse sets `clrBusy` one cycle later. At the next strobe, the whole secondary memory is zeroed and `clrBusy` returns to 0. The zeros appear on `segOut` from the strobe after that.
- R10: A byte write with `wrWide` = 0 stores `wrData[7:0]` at byte `wrAddr` of the main memory (`wrBlink` = 0) or the secondary memory (`wrBlink` = 1). Byte k bit i maps to segment 8k+i. A wide write ignores `wrAddr[0]`: it stores `wrData[7:0]` at the even byte and `wrData[15:8]` at the next byte.
- R11: When a write to the secondary memory meets the strobe that performs a pending clear, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | 1 | One pulse per period of the display source clock |
| frameStb | input | 1 | Single-cycle frame-boundary strobe |
| dispOn | input | 1 | Global display enable |
| blinkMode | input | 2 | 00 none, 01 flagged segments, 10 all segments, 11 alternate pictures |
| dispSel | input | 1 | Manual picture select: 0 main, 1 secondary |
| highMux | input | 1 | 1 when the multiplex ratio is five or more |
| blkDiv | input | 3 | Blink divider field |
| blkPre | input | 3 | Blink prescaler field |
| clrReq | input | 1 | Pulse that requests clearing of the secondary memory |
| wrEn | input | 1 | Memory write enable |
| wrBlink | input | 1 | Write target: 0 main, 1 secondary |
| wrWide | input | 1 | 16-bit write to an even byte pair |
| wrAddr | input | 2 | Byte address |
| wrData | input | 16 | Write data |
| clrBusy | output | 1 | Clear pending |
| segOut | output | 32 | Per-segment on/off result |

## Verification
Several properties are checked on every cycle: `segOut` stays frozen without a strobe, a strobe with the display disabled gives all zeros, and a pending clear overrides a colliding write. In addition, the divider stays parked while the effective mode is 00, the blink phase moves only on a source pulse, the clear-pending flag drops only at a strobe, and flagged blinking and picture swapping are suppressed at a high multiplex ratio. Only the bench scenarios can show the exact half-period length in source pulses, the segment values under each mode, and the byte and word mapping of writes. The same holds for which picture comes first in alternation, and for the one-frame lag before a cleared memory becomes visible.

// File: rtl/segBlinkPkg.sv
package segBlinkPkg;

  typedef enum logic [1:0] {
    BLK_NONE      = 2'b00,
    BLK_FLAGGED   = 2'b01,
    BLK_ALL       = 2'b10,
    BLK_ALTERNATE = 2'b11
  } blinkMode_e;

  // strobes and selects passed from control to datapath
  typedef struct packed {
    logic applyFrame;
    logic clearBlink;
    logic displayOn;
    logic blankAll;
    logic blankFlagged;
    logic showBlink;
  } ctlStrobes_t;

endpackage

// File: rtl/segBlinkControl.sv
module segBlinkControl
  import segBlinkPkg::*;
#(
  parameter int DIV_W = 3,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcTick,
  input  logic             frameStb,
  input  logic             dispOn,
  input  logic [1:0]       blinkMode,
  input  logic             dispSel,
  input  logic             highMux,
  input  logic [DIV_W-1:0] blkDiv,
  input  logic [PRE_W-1:0] blkPre,
  input  logic             clrReq,
  output logic             clrBusy,
  output ctlStrobes_t      ctl
);

  localparam int BASE_SHIFT = 8;
  localparam int CNT_W      = DIV_W + 1 + BASE_SHIFT + (2 ** PRE_W) - 1;

  blinkMode_e       effMode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] divPlusOne;
  logic [7:0]       shiftAmt;
  logic             phaseOff;
  logic             clrPend;
  logic             lastCnt;

  // high multiplex ratio keeps only whole-display blinking
  always_comb begin
    if (highMux) effMode = (blinkMode == 2'b10) ? BLK_ALL : BLK_NONE;
    else         effMode = blinkMode_e'(blinkMode);
  end

  assign divPlusOne = CNT_W'(blkDiv) + CNT_W'(1);
  assign shiftAmt   = 8'(blkPre) + 8'(BASE_SHIFT);
  assign halfLen    = divPlusOne << shiftAmt;
  assign lastCnt    = (cnt == halfLen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      phaseOff <= 1'b1;
    end else if (effMode == BLK_NONE) begin
      cnt      <= '0;
      phaseOff <= 1'b1;
    end else if (srcTick) begin
      if (lastCnt) begin
        cnt      <= '0;
        phaseOff <= ~phaseOff;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    clrPend <= 1'b0;
    else if (frameStb && clrPend) clrPend <= 1'b0;
    else if (clrReq)              clrPend <= 1'b1;
  end

  assign clrBusy = clrPend;

  always_comb begin
    ctl.applyFrame   = frameStb;
    ctl.clearBlink   = clrPend;
    ctl.displayOn    = dispOn;
    ctl.blankAll     = (effMode == BLK_ALL) && phaseOff;
    ctl.blankFlagged = (effMode == BLK_FLAGGED) && phaseOff;
    if (effMode == BLK_ALTERNATE) ctl.showBlink = phaseOff;
    else                          ctl.showBlink = (effMode == BLK_NONE) && dispSel && !highMux;
  end

  // R8
  divider_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == BLK_NONE) |=> (cnt == '0 && phaseOff));

  // R8
  phase_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(effMode != BLK_NONE) && !$past(srcTick)) |-> $stable(phaseOff));

  // R9
  clr_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clrPend) |-> $past(frameStb));

  // R7
  high_mux_modes_chk: assert property (@(posedge clk) disable iff (!rstN)
    highMux |-> (!ctl.blankFlagged && !ctl.showBlink));

endmodule

// File: rtl/segBlinkDatapath.sv
module segBlinkDatapath
  import segBlinkPkg::*;
#(
  parameter int NUM_SEG = 32,
  localparam int NUM_BYTES = NUM_SEG / 8,
  localparam int ADDR_W = $clog2(NUM_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic               wrEn,
  input  logic               wrBlink,
  input  logic               wrWide,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [15:0]        wrData,
  output logic [NUM_SEG-1:0] segOut
);

  logic [NUM_SEG-1:0] mainMem;
  logic [NUM_SEG-1:0] blinkMem;
  logic [NUM_SEG-1:0] selMem;
  logic [NUM_SEG-1:0] blankMask;
  logic [NUM_SEG-1:0] nextSeg;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : gByte
    logic       byteHit;
    logic [7:0] byteData;

    assign byteHit  = wrWide ? ((wrAddr >> 1) == ADDR_W'(k / 2)) : (wrAddr == ADDR_W'(k));
    assign byteData = (wrWide && (k % 2 == 1)) ? wrData[15:8] : wrData[7:0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mainMem[k*8 +: 8]  <= '0;
        blinkMem[k*8 +: 8] <= '0;
      end else begin
        if (wrEn && !wrBlink && byteHit) mainMem[k*8 +: 8] <= byteData;
        if (ctl.applyFrame && ctl.clearBlink)  blinkMem[k*8 +: 8] <= '0;
        else if (wrEn && wrBlink && byteHit)   blinkMem[k*8 +: 8] <= byteData;
      end
    end
  end

  always_comb begin
    selMem = ctl.showBlink ? blinkMem : mainMem;
    if (ctl.blankAll)          blankMask = '0;
    else if (ctl.blankFlagged) blankMask = ~blinkMem;
    else                       blankMask = '1;
    nextSeg = ctl.displayOn ? (selMem & blankMask) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               segOut <= '0;
    else if (ctl.applyFrame) segOut <= nextSeg;
  end

  // R1
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.applyFrame) |-> $stable(segOut));

  // R2
  blank_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.applyFrame && !ctl.displayOn) |=> (segOut == '0));

  // R11
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.applyFrame && ctl.clearBlink) |=> (blinkMem == '0));

endmodule

// File: rtl/segBlinkCtl.sv
module segBlinkCtl
  import segBlinkPkg::*;
#(
  parameter int NUM_SEG = 32,
  parameter int DIV_W = 3,
  parameter int PRE_W = 3,
  localparam int ADDR_W = $clog2(NUM_SEG / 8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               srcTick,
  input  logic               frameStb,
  input  logic               dispOn,
  input  logic [1:0]         blinkMode,
  input  logic               dispSel,
  input  logic               highMux,
  input  logic [DIV_W-1:0]   blkDiv,
  input  logic [PRE_W-1:0]   blkPre,
  input  logic               clrReq,
  input  logic               wrEn,
  input  logic               wrBlink,
  input  logic               wrWide,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [15:0]        wrData,
  output logic               clrBusy,
  output logic [NUM_SEG-1:0] segOut
);

  ctlStrobes_t ctl;

  segBlinkControl #(.DIV_W(DIV_W), .PRE_W(PRE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .frameStb(frameStb),
    .dispOn(dispOn), .blinkMode(blinkMode), .dispSel(dispSel),
    .highMux(highMux), .blkDiv(blkDiv), .blkPre(blkPre),
    .clrReq(clrReq), .clrBusy(clrBusy), .ctl(ctl)
  );

  segBlinkDatapath #(.NUM_SEG(NUM_SEG)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrEn(wrEn), .wrBlink(wrBlink),
    .wrWide(wrWide), .wrAddr(wrAddr), .wrData(wrData), .segOut(segOut)
  );

endmodule

// File: tb/tb_segBlinkCtl.sv
module tb_segBlinkCtl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MAIN_PIC = 32'h4433_2211;

  logic clk = 0, rstN = 0, srcTick = 0, frameStb = 0, dispOn = 0;
  logic [1:0] blinkMode = 2'b00;
  logic dispSel = 0, highMux = 0, clrReq = 0;
  logic [2:0] blkDiv = 0, blkPre = 0;
  logic wrEn = 0, wrBlink = 0, wrWide = 0;
  logic [1:0] wrAddr = 0;
  logic [15:0] wrData = 0;
  logic clrBusy;
  logic [31:0] segOut;

  int total = 0, failed = 0, holdViol = 0;
  logic lastStb = 0, monArmed = 0;
  logic [31:0] prevSeg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segBlinkCtl dut (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .frameStb(frameStb),
    .dispOn(dispOn), .blinkMode(blinkMode), .dispSel(dispSel),
    .highMux(highMux), .blkDiv(blkDiv), .blkPre(blkPre), .clrReq(clrReq),
    .wrEn(wrEn), .wrBlink(wrBlink), .wrWide(wrWide), .wrAddr(wrAddr),
    .wrData(wrData), .clrBusy(clrBusy), .segOut(segOut)
  );

  // R1 monitor: output may only move after an edge that saw a strobe
  always @(posedge clk) lastStb <= frameStb;
  always @(negedge clk) begin
    if (monArmed && !lastStb && segOut !== prevSeg) holdViol++;
    prevSeg = segOut;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame();
    @(negedge clk) frameStb = 1;
    @(negedge clk) frameStb = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk) srcTick = 1;
    repeat (n) @(negedge clk);
    srcTick = 0;
  endtask

  task automatic wrByte(input logic tgt, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk) begin wrEn = 1; wrBlink = tgt; wrWide = 0; wrAddr = a; wrData = {8'h00, d}; end
    @(negedge clk) wrEn = 0;
  endtask

  task automatic wrWord(input logic tgt, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk) begin wrEn = 1; wrBlink = tgt; wrWide = 1; wrAddr = a; wrData = d; end
    @(negedge clk) begin wrEn = 0; wrWide = 0; end
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk) blinkMode = m;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    monArmed = 1;
    check("R1 reset segOut", segOut, 32'h0);
    check("R9 reset clrBusy", {31'h0, clrBusy}, 32'h0);
  endtask

  task automatic testWrites();
    wrByte(0, 2'd0, 8'h11); wrByte(0, 2'd1, 8'h22);
    wrByte(0, 2'd2, 8'h33); wrByte(0, 2'd3, 8'h44);
    wrWord(1, 2'd3, 16'hA5C3);
    wrWord(1, 2'd0, 16'h0F0F);
    check("R1 no strobe no change", segOut, 32'h0);
    dispOn = 1;
    frame();
    check("R10 byte writes main", segOut, MAIN_PIC);
    @(negedge clk) dispSel = 1;
    check("R1 select held until strobe", segOut, MAIN_PIC);
    frame();
    check("R3 R10 wide writes secondary", segOut, 32'hA5C3_0F0F);
    @(negedge clk) dispSel = 0;
    frame();
    check("R3 back to main", segOut, MAIN_PIC);
  endtask

  task automatic testDisplayOff();
    @(negedge clk) dispOn = 0;
    frame();
    check("R2 display off", segOut, 32'h0);
    @(negedge clk) dispOn = 1;
    frame();
    check("R2 display on", segOut, MAIN_PIC);
  endtask

  task automatic testFlagged();
    wrWord(1, 2'd0, 16'h00FF);
    wrWord(1, 2'd2, 16'h0000);
    setMode(2'b01);
    frame();
    check("R4 flagged off", segOut, 32'h4433_2200);
    ticks(255);
    frame();
    check("R8 still off before half period", segOut, 32'h4433_2200);
    ticks(1);
    frame();
    check("R4 R8 flagged back on", segOut, MAIN_PIC);
    setMode(2'b00);
    frame();
  endtask

  task automatic testAll();
    setMode(2'b10);
    frame();
    check("R5 all off", segOut, 32'h0);
    ticks(256);
    frame();
    check("R5 all on", segOut, MAIN_PIC);
    setMode(2'b00);
    @(negedge clk) begin blkDiv = 3'd1; blkPre = 3'd1; end
    setMode(2'b10);
    frame();
    check("R8 scaled off", segOut, 32'h0);
    ticks(1023);
    frame();
    check("R8 scaled still off", segOut, 32'h0);
    ticks(1);
    frame();
    check("R8 scaled on after 1024", segOut, MAIN_PIC);
    setMode(2'b00);
    @(negedge clk) begin blkDiv = 0; blkPre = 0; end
    frame();
  endtask

  task automatic testAlternate();
    setMode(2'b11);
    frame();
    check("R6 secondary first", segOut, 32'h0000_00FF);
    ticks(256);
    frame();
    check("R6 then main", segOut, MAIN_PIC);
    ticks(256);
    frame();
    check("R6 secondary again", segOut, 32'h0000_00FF);
    setMode(2'b00);
    frame();
  endtask

  task automatic testHighMux();
    @(negedge clk) begin highMux = 1; dispSel = 1; end
    frame();
    check("R7 select ignored", segOut, MAIN_PIC);
    setMode(2'b01);
    frame();
    check("R7 flagged disabled", segOut, MAIN_PIC);
    setMode(2'b11);
    frame();
    ticks(256);
    frame();
    check("R7 alternate disabled", segOut, MAIN_PIC);
    setMode(2'b10);
    frame();
    check("R7 all blink kept", segOut, 32'h0);
    setMode(2'b00);
    @(negedge clk) highMux = 0;
    frame();
  endtask

  task automatic testClear();
    @(negedge clk) clrReq = 1;
    @(negedge clk) clrReq = 0;
    check("R9 busy after request", {31'h0, clrBusy}, 32'h1);
    frame();
    check("R9 old contents on clearing strobe", segOut, 32'h0000_00FF);
    check("R9 busy dropped", {31'h0, clrBusy}, 32'h0);
    frame();
    check("R9 cleared memory shown", segOut, 32'h0);
  endtask

  task automatic testClearWins();
    wrWord(1, 2'd0, 16'h1234);
    frame();
    check("R10 secondary rewritten", segOut, 32'h0000_1234);
    @(negedge clk) clrReq = 1;
    @(negedge clk) clrReq = 0;
    @(negedge clk) begin frameStb = 1; wrEn = 1; wrBlink = 1; wrWide = 0; wrAddr = 2'd1; wrData = 16'h0077; end
    @(negedge clk) begin frameStb = 0; wrEn = 0; end
    frame();
    check("R11 clear beats write", segOut, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failed++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    testReset();
    testWrites();
    testDisplayOff();
    testFlagged();
    testAll();
    testAlternate();
    testHighMux();
    testClear();
    testClearWins();
    @(negedge clk);
    check("R1 output held between strobes", holdViol, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule